// File: doc/BRIEF.md
# Strobed Digital Input Capture Unit

This block samples a 32-bit parallel input bus on each rising edge of an external sample strobe and stores the samples in an on-chip FIFO. A downstream consumer, typically a DMA engine, drains that FIFO one 32-bit word at a time. The sample width is selectable as 8, 16 or 32 bits. Narrow samples are packed little-endian into 32-bit words. When capture stops, a partly filled word is flushed into the FIFO with its unused lanes set to zero.

A start pulse empties the FIFO, clears the overrun flag and begins capture. Capture can begin at once, or the unit can be armed so that capture begins only when the external trigger input is seen high. The acknowledge output tells the external source that it may keep strobing. It is high only while capture runs and the FIFO holds fewer words than the almost-full threshold. A word that arrives while the FIFO is full is dropped, and this raises a sticky overrun flag. The flag stays set until software pulses its clear input or issues a new start.

The strobe and the trigger must be synchronous to `clk`, or already synchronised to it. The configuration inputs must be held steady while capture runs.

Top module: `strobe_capture_top`

## Requirements
- R1: After reset, `ext_ack`, `ovr_flag` and `rd_valid` are all low.
- R2: A `cap_start` pulse with `cfg_wait_trig` low starts capture at once. `ext_ack` is high on the next cycle, and later strobes are captured.
- R3: A `cap_start` pulse with `cfg_wait_trig` high arms the unit. While it is armed, `ext_ack` stays low and strobes are ignored. Once `ext_trig` is seen high, capture runs and `ext_ack` rises.
- R4: Each rising edge of `ext_strobe` takes exactly one sample. Holding the strobe high for several cycles does not take extra samples.
- R5: With `cfg_width` = 2'b10 or 2'b11 (32-bit), each sample becomes one FIFO word. Words are read out in the order they were sampled.
- R6: With `cfg_width` = 2'b01 (16-bit), the first sample `ext_data[15:0]` fills word bits [15:0] and the second fills bits [31:16].
- R7: With `cfg_width` = 2'b00 (8-bit), four successive `ext_data[7:0]` samples fill word bytes 0, 1, 2 and 3 in that order. Byte 0 is bits [7:0].
- R8: A `cap_stop` pulse ends capture.
  - A partial word is written with its unfilled lanes set to zero.
  - After the stop, strobes are ignored and `ext_ack` is low.
- R9: While capture runs, `ext_ack` is high exactly when the FIFO holds fewer than DEPTH − AF_MARGIN words.
- R10: A word that arrives while the FIFO holds DEPTH words is discarded, and `ovr_flag` is set. The stored words are unchanged.
- R11: `ovr_flag` stays set until an `ovr_clr` pulse clears it. A `cap_start` pulse also clears it and empties the FIFO.
- R12: `rd_valid` is high whenever the FIFO is not empty, and `rd_data` shows the oldest word. `rd_en` with `rd_valid` removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Sample width: 00 = 8-bit, 01 = 16-bit, 1x = 32-bit |
| cfg_wait_trig | input | 1 | 1 = arm at start and wait for the trigger |
| cap_start | input | 1 | Start pulse: clears the FIFO and the flag, begins or arms capture |
| cap_stop | input | 1 | Stop pulse: ends capture and flushes a partial word |
| ext_trig | input | 1 | External trigger, level-sensed while armed |
| ext_strobe | input | 1 | External sample strobe; the rising edge samples |
| ext_data | input | 32 | Parallel input bus |
| ext_ack | output | 1 | Source may keep strobing |
| ovr_clr | input | 1 | Write-1 pulse that clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun status |
| rd_en | input | 1 | Consumer pops the head word |
| rd_data | output | 32 | Head word of the FIFO |
| rd_valid | output | 1 | FIFO is not empty |

## Verification
The main capture path is tried in four ways:
- **Packing.** Counting byte, half-word and word samples in each width mode separates a lane-order error from a sample-count error.
- **Held strobe.** A strobe held high for several cycles separates edge detection from level sensing.
- **Stops.** Stops after an odd number of narrow samples show whether the flush zero-fills the unused lanes.
- **Fill past full.** Filling the FIFO beyond full, with `ext_ack` checked after each word, shows three things: the almost-full point, that the dropped words never reach the reader, and that the flag outlives a full drain.

Arming with strobes sent before the trigger separates gated capture from free-running capture.

// File: rtl/scap_pkg.sv
// Shared types for the strobed capture unit.
package scap_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    // Sample width selection; 2'b11 is treated as 32-bit.
    typedef enum logic [1:0] {
        WID_8  = 2'b00,
        WID_16 = 2'b01,
        WID_32 = 2'b10
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_RUN   = 2'b10
    } cap_state_e;
endpackage

// File: rtl/scap_ctrl.sv
// Capture sequencer: idle / armed / running, plus strobe edge detection.
// Assumes the strobe and the trigger are synchronous to clk.
// A start pulse wins over a stop pulse given in the same cycle.
module scap_ctrl
    import scap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic wait_trig,
    input  logic trig,
    input  logic strobe,
    output logic running,
    output logic armed,
    output logic take,
    output logic flush
);
    cap_state_e state;
    logic       strobe_q;

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (start) begin
            state <= wait_trig ? ST_ARMED : ST_RUN;
        end else if (stop) begin
            state <= ST_IDLE;
        end else if (state == ST_ARMED && trig) begin
            state <= ST_RUN;
        end
    end

    // Previous strobe level, used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Decoded state and the sample and flush qualifiers.
    always_comb begin
        running = (state == ST_RUN);
        armed   = (state == ST_ARMED);
        take    = running && strobe && !strobe_q && !start && !stop;
        flush   = stop && !start;
    end

    a_r2_nowait_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wait_trig) |=> running);
    a_r3_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wait_trig) |=> (armed && !running));
    a_r3_trigger_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && trig && !start && !stop) |=> running);
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!running && !armed));
endmodule

// File: rtl/scap_packer.sv
// Packs narrow samples little-endian into 32-bit words.
// Emits a registered word one cycle after the sample that completes it, or
// after a flush when a partial word is held (unfilled lanes are zero).
// Assumes the width setting is stable while samples arrive.
module scap_packer
    import scap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              flush,
    input  logic [1:0]        width,
    input  logic [WORD_W-1:0] din,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int SW = $clog2(LANES);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [SW-1:0]     slot;
    logic [SW-1:0]     slot_nxt;
    logic              last;
    logic              wide;
    logic              half;

    assign wide = width[1];
    assign half = (width == WID_16);

    // Per-lane byte source: new sample data for lanes this sample covers.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] byte_v;
        // Choose this lane's byte from the accumulator or the incoming sample.
        always_comb begin
            byte_v = acc[b*8 +: 8];
            if (wide) begin
                byte_v = din[b*8 +: 8];
            end else if (half) begin
                if (slot == SW'(b & 2)) byte_v = din[(b % 2)*8 +: 8];
            end else begin
                if (slot == SW'(b)) byte_v = din[7:0];
            end
        end
        assign merged[b*8 +: 8] = byte_v;
    end

    // Next slot and word-complete detection for the selected width.
    always_comb begin
        if (wide) begin
            last     = 1'b1;
            slot_nxt = '0;
        end else if (half) begin
            last     = slot[1];
            slot_nxt = slot + SW'(2);
        end else begin
            last     = (slot == SW'(LANES-1));
            slot_nxt = slot + SW'(1);
        end
    end

    // Accumulator, slot pointer and word output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc      <= '0;
            slot     <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (take) begin
                if (last) begin
                    word     <= merged;
                    word_vld <= 1'b1;
                    acc      <= '0;
                    slot     <= '0;
                end else begin
                    acc  <= merged;
                    slot <= slot_nxt;
                end
            end else if (flush && slot != '0) begin
                word     <= acc;
                word_vld <= 1'b1;
                acc      <= '0;
                slot     <= '0;
            end
        end
    end

    a_r5_wide_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wide && !clr) |=> word_vld);
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !take && !clr) |=> (slot == '0));
    a_r4_idle_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !flush) |=> !word_vld);
endmodule

// File: rtl/scap_fifo.sv
// Capture FIFO with a first-word-fall-through read side, almost-full
// indication and a sticky overrun flag set by a push while full.
// A push while full is dropped; clr empties the FIFO and clears the flag.
module scap_fifo
    import scap_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int AF_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    input  logic              ovr_clr,
    output logic [WORD_W-1:0] rdata,
    output logic              not_empty,
    output logic              below_af,
    output logic              ovr
);
    localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW       = $clog2(DEPTH + 1);
    localparam int AF_LEVEL = DEPTH - AF_MARGIN;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              full;
    logic              do_push;
    logic              do_pop;
    logic              drop;

    // Occupancy decode and the accepted push and pop.
    always_comb begin
        full      = (count == CW'(DEPTH));
        not_empty = (count != '0);
        below_af  = (count < CW'(AF_LEVEL));
        do_push   = push && !full;
        drop      = push && full;
        do_pop    = pop && not_empty;
        rdata     = mem[rd_ptr];
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    // Sticky overrun flag; setting wins over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ovr <= 1'b0;
        else if (drop)     ovr <= 1'b1;
        else if (ovr_clr)  ovr <= 1'b0;
    end

    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full);
    a_r10_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> ovr);
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr && !clr) |=> ovr);
    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!not_empty && !ovr));
    a_r12_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && not_empty && !push && !clr) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/strobe_capture_top.sv
// Strobed digital input capture unit: sequencer, packer and FIFO.
// The acknowledge output is high while capture runs and the FIFO is below
// its almost-full threshold. Inputs are assumed synchronous to clk.
module strobe_capture_top
    import scap_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int AF_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_wait_trig,
    input  logic              cap_start,
    input  logic              cap_stop,
    input  logic              ext_trig,
    input  logic              ext_strobe,
    input  logic [WORD_W-1:0] ext_data,
    output logic              ext_ack,
    input  logic              ovr_clr,
    output logic              ovr_flag,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              running;
    logic              armed;
    logic              take;
    logic              flush;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              below_af;

    scap_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cap_start),
        .stop      (cap_stop),
        .wait_trig (cfg_wait_trig),
        .trig      (ext_trig),
        .strobe    (ext_strobe),
        .running   (running),
        .armed     (armed),
        .take      (take),
        .flush     (flush)
    );

    scap_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cap_start),
        .take     (take),
        .flush    (flush),
        .width    (cfg_width),
        .din      (ext_data),
        .word_vld (word_vld),
        .word     (word)
    );

    scap_fifo #(.DEPTH(DEPTH), .AF_MARGIN(AF_MARGIN)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cap_start),
        .push      (word_vld),
        .wdata     (word),
        .pop       (rd_en),
        .ovr_clr   (ovr_clr),
        .rdata     (rd_data),
        .not_empty (rd_valid),
        .below_af  (below_af),
        .ovr       (ovr_flag)
    );

    // Flow-control acknowledge toward the external source.
    assign ext_ack = running && below_af;

    a_r3_no_ack_armed: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !ext_ack);
    a_r9_ack_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
        !below_af |-> !ext_ack);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ext_ack && !ovr_flag && !rd_valid));
endmodule

// File: tb/tb_strobe_capture_top.sv
// Scoreboard bench: driver tasks model the expected words into a queue and
// a monitor process pops and compares them as the FIFO presents words.
module tb_strobe_capture_top;
    localparam int DEPTH  = 16;
    localparam int MARGIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'b10;
    logic        cfg_wait_trig = 1'b0;
    logic        cap_start = 1'b0;
    logic        cap_stop = 1'b0;
    logic        ext_trig = 1'b0;
    logic        ext_strobe = 1'b0;
    logic [31:0] ext_data = '0;
    logic        ext_ack;
    logic        ovr_clr = 1'b0;
    logic        ovr_flag;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int          checks = 0;
    int          errs = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] m_acc = '0;
    int          m_slot = 0;
    bit          m_ovr = 1'b0;

    always #2 clk = ~clk;

    strobe_capture_top #(.DEPTH(DEPTH), .AF_MARGIN(MARGIN)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .cfg_wait_trig(cfg_wait_trig), .cap_start(cap_start),
        .cap_stop(cap_stop), .ext_trig(ext_trig), .ext_strobe(ext_strobe),
        .ext_data(ext_data), .ext_ack(ext_ack), .ovr_clr(ovr_clr),
        .ovr_flag(ovr_flag), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
        end
    endtask

    // Model: add a finished word, or note an overrun if the FIFO is full.
    task automatic model_word(input logic [31:0] w);
        if (exp_q.size() >= DEPTH) m_ovr = 1'b1;
        else                       exp_q.push_back(w);
    endtask

    // Model: pack one sample according to the current width.
    task automatic model_sample(input logic [31:0] d);
        if (cfg_width == 2'b00) begin
            m_acc[m_slot*8 +: 8] = d[7:0];
            m_slot++;
            if (m_slot == 4) begin model_word(m_acc); m_acc = '0; m_slot = 0; end
        end else if (cfg_width == 2'b01) begin
            m_acc[m_slot*16 +: 16] = d[15:0];
            m_slot++;
            if (m_slot == 2) begin model_word(m_acc); m_acc = '0; m_slot = 0; end
        end else begin
            model_word(d);
        end
    endtask

    task automatic strobe(input logic [31:0] d, input int hold, input bit taken);
        @(negedge clk);
        ext_data   = d;
        ext_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        ext_strobe = 1'b0;
        @(negedge clk);
        if (taken) model_sample(d);
    endtask

    task automatic do_start(input logic [1:0] w, input bit wt);
        @(negedge clk);
        cfg_width     = w;
        cfg_wait_trig = wt;
        cap_start     = 1'b1;
        @(negedge clk);
        cap_start = 1'b0;
        exp_q.delete();
        m_acc  = '0;
        m_slot = 0;
        m_ovr  = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        cap_stop = 1'b1;
        @(negedge clk);
        cap_stop = 1'b0;
        if (m_slot != 0) begin model_word(m_acc); m_acc = '0; m_slot = 0; end
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        mon_on = 1'b1;
        repeat (DEPTH * 2 + 4) @(negedge clk);
        mon_on = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, req, "expected words not seen", 32'(exp_q.size()), 0);
        check(rd_valid == 1'b0, req, "FIFO not empty after drain", 32'(rd_valid), 0);
    endtask

    // Monitor: compare each presented word with the scoreboard head and pop it.
    always @(negedge clk) begin
        if (mon_on && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12", "unexpected word", rd_data, 32'hx);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rd_data === e, "R5/R6/R7/R12", "read word", rd_data, e);
            end
            rd_en = 1'b1;
        end else begin
            rd_en = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(ext_ack == 1'b0, "R1", "ack after reset", 32'(ext_ack), 0);
        check(ovr_flag == 1'b0, "R1", "overrun after reset", 32'(ovr_flag), 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", 32'(rd_valid), 0);

        // R2, R5, R4: immediate start, 32-bit words, held strobe
        do_start(2'b10, 1'b0);
        check(ext_ack == 1'b1, "R2", "ack after no-wait start", 32'(ext_ack), 1);
        strobe(32'hA1B2C3D4, 1, 1'b1);
        strobe(32'h01234567, 1, 1'b1);
        strobe(32'hDEADBEEF, 5, 1'b1);   // R4: held high, one sample only
        strobe(32'h0F0F0F0F, 2, 1'b1);
        drain("R4");

        // R6 and R8: 16-bit packing with a partial flush
        do_start(2'b01, 1'b0);
        strobe(32'hFFFF1111, 1, 1'b1);
        strobe(32'hEEEE2222, 1, 1'b1);
        strobe(32'hDDDD3333, 1, 1'b1);
        do_stop();
        check(ext_ack == 1'b0, "R8", "ack after stop", 32'(ext_ack), 0);
        strobe(32'h99999999, 1, 1'b0);   // R8: ignored after stop
        drain("R6");

        // R7 and R8: 8-bit packing, six bytes
        do_start(2'b00, 1'b0);
        strobe(32'h00000011, 1, 1'b1);
        strobe(32'h00000022, 1, 1'b1);
        strobe(32'h00000033, 1, 1'b1);
        strobe(32'h00000044, 1, 1'b1);
        strobe(32'hAB000055, 1, 1'b1);
        strobe(32'h00CD0066, 1, 1'b1);
        do_stop();
        drain("R7");

        // R3: armed start ignores strobes until the trigger
        do_start(2'b10, 1'b1);
        check(ext_ack == 1'b0, "R3", "ack while armed", 32'(ext_ack), 0);
        strobe(32'h55555555, 1, 1'b0);
        repeat (2) @(negedge clk);
        check(rd_valid == 1'b0, "R3", "word captured while armed", 32'(rd_valid), 0);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        check(ext_ack == 1'b1, "R3", "ack after trigger", 32'(ext_ack), 1);
        strobe(32'h12121212, 1, 1'b1);
        strobe(32'h34343434, 1, 1'b1);
        drain("R3");

        // R9, R10: fill past full with no reader
        do_start(2'b11, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            strobe(32'h100 + 32'(i), 1, 1'b1);
            check(ext_ack == (exp_q.size() < DEPTH - MARGIN), "R9",
                  "ack versus level", 32'(ext_ack), 32'(exp_q.size() < DEPTH - MARGIN));
        end
        check(ovr_flag == 1'b0, "R10", "overrun at exactly full", 32'(ovr_flag), 0);
        strobe(32'hBAD00001, 1, 1'b1);
        check(ovr_flag == m_ovr, "R10", "overrun after extra word", 32'(ovr_flag), 32'(m_ovr));
        strobe(32'hBAD00002, 1, 1'b1);
        check(ovr_flag == 1'b1, "R11", "overrun held", 32'(ovr_flag), 1);
        drain("R10");
        check(ovr_flag == 1'b1, "R11", "overrun kept after drain", 32'(ovr_flag), 1);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(ovr_flag == 1'b0, "R11", "overrun after clear", 32'(ovr_flag), 0);

        // R11: a new start clears both the flag and the FIFO
        for (int i = 0; i <= DEPTH; i++) strobe(32'h200 + 32'(i), 1, 1'b1);
        check(ovr_flag == 1'b1, "R11", "overrun before restart", 32'(ovr_flag), 1);
        do_start(2'b10, 1'b0);
        check(ovr_flag == 1'b0, "R11", "overrun after restart", 32'(ovr_flag), 0);
        check(rd_valid == 1'b0, "R11", "FIFO after restart", 32'(rd_valid), 0);
        check(ext_ack == 1'b1, "R9", "ack after restart", 32'(ext_ack), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule